// File: doc/BRIEF.md
# Biphase-Mark Audio Frame Serializer

This block produces the single-wire line signal of a consumer two-channel digital audio link. It runs on a line clock of 128 times the audio sample rate, so each clock cycle carries one half-cell of the line code. Each frame holds two 32-slot subframes, one per channel. A subframe starts with a four-slot sync preamble. The next 24 slots carry audio, sent least significant bit first. The last four slots carry validity, user, channel-status and parity bits. Every slot after the preamble is sent with biphase-mark coding.

The channel-status and user-data streams each come from a block of `BLK_WORDS` words of `WORD_W` bits, one bit per frame. With the defaults this is a 192-frame block built from six 32-bit words. Software writes new words into a staging copy. The serializer reads a separate shadow copy, and the shadow is refreshed from staging only at a block boundary, or continuously while transmission is off. A ready flag for each block tells the writer when the staging copy has been taken over. When no sample pair is offered at the start of a frame, the block sends a null frame, and an input selects how the null frame's validity bit is marked.

Top module: `bmc_tx_serializer`

## Requirements
- R1: After reset, and for every cycle in which `tx_en` was low at the previous edge, `sdo` is 0. While `tx_en` is low, `smp_take` and `block_end` are 0. Both ready flags are 1 after reset.
- R2: With `tx_en` high, each clock cycle emits one half-cell. A frame is 128 half-cells: channel A's subframe first, then channel B's. Each subframe has 32 slots of two half-cells each. Slot 4+i carries audio bit i for i = 0..23, slot 28 carries V, slot 29 carries U, slot 30 carries C and slot 31 carries P.
- R3: Every slot from 4 to 31 begins with a level change. A slot carrying 1 has a second level change between its two half-cells, and a slot carrying 0 has none.
- R4: Slots 0 to 3 carry an 8-half-cell preamble, listed here in send order. Each value is XORed with the line level held just before the subframe starts. The patterns are 1,1,1,0,1,0,0,0 for channel A of block frame 0; 1,1,1,0,0,0,1,0 for channel A of every other frame; and 1,1,1,0,0,1,0,0 for channel B.
- R5: P is chosen so that slots 4 to 31 of each subframe hold an even number of ones.
- R6: In the first cycle of a frame, with `tx_en` high and `smp_avail` high, `smp_take` is high for exactly that cycle. At that edge `aud_a`, `aud_b`, `val_a` and `val_b` are captured for the whole frame.
- R7: If `smp_avail` is low in the first cycle of a frame, a null frame is sent and `smp_take` stays low. A null frame has all audio bits at 0, and V in both subframes is 1 when `null_ok` is 0 and 0 when `null_ok` is 1.
- R8: In a frame with a sample pair, V is the captured `val_a` in channel A's subframe and the captured `val_b` in channel B's subframe.
- R9: Frame k of a block carries user bit k in both subframes. Bit k is bit k mod `WORD_W` of shadow user word k div `WORD_W`, so bit 0 of word 0 goes out first.
- R10: Channel-status bits follow the same indexing. Writes change only the staging words, and the shadow copies staging only at the edge that ends a block or at any edge where `tx_en` is low. Data written during a block therefore first appears in the next block.
- R11: A ready flag drops to 0 at the edge where its write strobe is sampled high. It returns to 1 at an edge where a copy takes place with no write strobe.
- R12: `block_end` is high for exactly one cycle: the last half-cell cycle of the final frame of each block.
- R13: When `tx_en` goes low, the frame and half-cell counters clear. Transmission therefore resumes at block frame 0, with the first preamble taken from a line level of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, 128 x sample rate, one half-cell per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| tx_en | input | 1 | Transmit enable; low holds the line at 0 and clears the counters |
| aud_a | input | 24 | Channel A sample |
| aud_b | input | 24 | Channel B sample |
| smp_avail | input | 1 | A sample pair is offered |
| smp_take | output | 1 | The offered pair is consumed at this edge |
| val_a | input | 1 | Validity bit value for channel A |
| val_b | input | 1 | Validity bit value for channel B |
| null_ok | input | 1 | 1: null frames are marked valid (V=0); 0: marked invalid (V=1) |
| cs_wr | input | 1 | Channel-status staging write strobe |
| cs_sel | input | SEL_W | Channel-status word index |
| cs_wdata | input | WORD_W | Channel-status word data |
| cs_rdy | output | 1 | Channel-status staging has been taken over |
| ud_wr | input | 1 | User-data staging write strobe |
| ud_sel | input | SEL_W | User-data word index |
| ud_wdata | input | WORD_W | User-data word data |
| ud_rdy | output | 1 | User-data staging has been taken over |
| block_end | output | 1 | Last cycle of a block |
| sdo | output | 1 | Biphase-mark line output |

## Verification
The bench builds the block with `BLK_WORDS` = 2 and `WORD_W` = 8, so a block is 16 frames, or 2048 cycles. That setting covers block wrap-around, the B preamble on each new block, the copy of a mid-block write at block end and many ready-flag cycles within a short run. Word-select decoding and per-frame bit indexing are the same logic at any block size, so the default 192-frame block adds nothing the short block leaves unexercised. The bench also covers underrun runs under both null-frame markings, changes of the validity inputs and a disable in the middle of a frame followed by a restart.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;

  localparam int AUD_W          = 24;
  localparam int SLOTS          = 32;
  localparam int HALF_PER_SUB   = 2 * SLOTS;
  localparam int HALF_PER_FRAME = 2 * HALF_PER_SUB;
  localparam int HC_W           = $clog2(HALF_PER_FRAME);
  localparam int SUB_W          = $clog2(HALF_PER_SUB);
  localparam int SLOT_W         = $clog2(SLOTS);
  localparam int PRE_HALVES     = 8;
  localparam int PRE_W          = $clog2(PRE_HALVES);
  localparam int NCH            = 2;

  localparam int SLOT_AUD0 = 4;
  localparam int SLOT_V    = 28;
  localparam int SLOT_U    = 29;
  localparam int SLOT_C    = 30;
  localparam int SLOT_P    = 31;

  typedef enum logic [1:0] {
    PRE_BLOCK = 2'd0,
    PRE_CHA   = 2'd1,
    PRE_CHB   = 2'd2
  } pre_kind_e;

  typedef struct packed {
    logic [AUD_W-1:0] aud;
    logic             vbit;
  } chan_word_t;

  // Bit i is half-cell i in send order, before XOR with the base level.
  function automatic logic [PRE_HALVES-1:0] pre_pattern(input pre_kind_e kind);
    logic [PRE_HALVES-1:0] pat;
    case (kind)
      PRE_BLOCK: pat = 8'h17;
      PRE_CHA:   pat = 8'h47;
      default:   pat = 8'h27;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/bmc_tx_timer.sv
module bmc_tx_timer
  import bmc_tx_pkg::*;
#(
  parameter int NFRAMES = 192,
  localparam int FRM_W  = $clog2(NFRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  output logic [HC_W-1:0]  hc,
  output logic [FRM_W-1:0] frm,
  output logic             frame_start,
  output logic             block_end
);

  localparam logic [HC_W-1:0]  HC_LAST  = HC_W'(HALF_PER_FRAME - 1);
  localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(NFRAMES - 1);

  logic [HC_W-1:0]  hc_q, hc_d;
  logic [FRM_W-1:0] frm_q, frm_d;
  logic             last_hc;

  assign last_hc = (hc_q == HC_LAST);

  always_comb begin
    hc_d  = hc_q;
    frm_d = frm_q;
    if (!tx_en) begin
      hc_d  = '0;
      frm_d = '0;
    end else begin
      hc_d = last_hc ? '0 : hc_q + 1'b1;
      if (last_hc) begin
        frm_d = (frm_q == FRM_LAST) ? '0 : frm_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q  <= '0;
      frm_q <= '0;
    end else begin
      hc_q  <= hc_d;
      frm_q <= frm_d;
    end
  end

  assign hc          = hc_q;
  assign frm         = frm_q;
  assign frame_start = tx_en && (hc_q == '0);
  assign block_end   = tx_en && last_hc && (frm_q == FRM_LAST);

endmodule

// File: rtl/bmc_tx_blockbuf.sv
module bmc_tx_blockbuf #(
  parameter int WORDS  = 6,
  parameter int WORD_W = 32,
  localparam int NBITS = WORDS * WORD_W,
  localparam int IDX_W = $clog2(NBITS),
  localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic              copy,
  input  logic [IDX_W-1:0]  bit_idx,
  output logic              bit_o,
  output logic              rdy
);

  logic [WORDS-1:0][WORD_W-1:0] stage_q, stage_d;
  logic [NBITS-1:0]             shadow_q, shadow_d;
  logic                         rdy_q, rdy_d;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = wr && (sel == SEL_W'(w));
    always_comb begin
      stage_d[w] = hit ? wdata : stage_q[w];
    end
  end

  always_comb begin
    shadow_d = copy ? stage_q : shadow_q;
    if (wr) begin
      rdy_d = 1'b0;
    end else if (copy) begin
      rdy_d = 1'b1;
    end else begin
      rdy_d = rdy_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      shadow_q <= '0;
      rdy_q    <= 1'b1;
    end else begin
      stage_q  <= stage_d;
      shadow_q <= shadow_d;
      rdy_q    <= rdy_d;
    end
  end

  assign bit_o = shadow_q[bit_idx];
  assign rdy   = rdy_q;

endmodule

// File: rtl/bmc_tx_framer.sv
module bmc_tx_framer
  import bmc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             smp_avail,
  input  logic [AUD_W-1:0] aud_a,
  input  logic [AUD_W-1:0] aud_b,
  input  logic             val_a,
  input  logic             val_b,
  input  logic             null_ok,
  input  logic             cs_bit,
  input  logic             ud_bit,
  input  logic             sub_sel,
  output logic [SLOTS-1:0] sub_bits,
  output logic             smp_take
);

  logic [AUD_W-1:0] aud_in [NCH];
  logic             val_in [NCH];
  chan_word_t       ch_q   [NCH];
  chan_word_t       ch_d   [NCH];
  chan_word_t       cur;

  assign aud_in[0] = aud_a;
  assign aud_in[1] = aud_b;
  assign val_in[0] = val_a;
  assign val_in[1] = val_b;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_comb begin
      ch_d[c] = ch_q[c];
      if (frame_start) begin
        if (smp_avail) begin
          ch_d[c].aud  = aud_in[c];
          ch_d[c].vbit = val_in[c];
        end else begin
          ch_d[c].aud  = '0;
          ch_d[c].vbit = ~null_ok;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_q[c] <= '0;
      end else begin
        ch_q[c] <= ch_d[c];
      end
    end
  end

  always_comb begin
    cur                           = sub_sel ? ch_q[1] : ch_q[0];
    sub_bits                      = '0;
    sub_bits[SLOT_AUD0 +: AUD_W]  = cur.aud;
    sub_bits[SLOT_V]              = cur.vbit;
    sub_bits[SLOT_U]              = ud_bit;
    sub_bits[SLOT_C]              = cs_bit;
    sub_bits[SLOT_P]              = ^sub_bits[SLOT_P-1:SLOT_AUD0];
  end

  assign smp_take = frame_start && smp_avail;

endmodule

// File: rtl/bmc_tx_encoder.sv
module bmc_tx_encoder
  import bmc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [HC_W-1:0]  hc,
  input  logic             first_frame,
  input  logic [SLOTS-1:0] sub_bits,
  output logic             line
);

  logic [SUB_W-1:0]      pos;
  logic [SLOT_W-1:0]     slot;
  logic                  second_half;
  logic                  in_pre;
  pre_kind_e             kind;
  logic [PRE_HALVES-1:0] pat;
  logic                  base;
  logic                  line_q, line_d;
  logic                  base_q, base_d;

  assign pos         = hc[SUB_W-1:0];
  assign slot        = pos[SUB_W-1:1];
  assign second_half = pos[0];
  assign in_pre      = (pos < SUB_W'(PRE_HALVES));

  always_comb begin
    if (hc[HC_W-1]) begin
      kind = PRE_CHB;
    end else if (first_frame) begin
      kind = PRE_BLOCK;
    end else begin
      kind = PRE_CHA;
    end
    pat  = pre_pattern(kind);
    base = (pos == '0) ? line_q : base_q;
  end

  always_comb begin
    line_d = line_q;
    base_d = base_q;
    if (!tx_en) begin
      line_d = 1'b0;
      base_d = 1'b0;
    end else begin
      if (pos == '0) begin
        base_d = line_q;
      end
      if (in_pre) begin
        line_d = pat[pos[PRE_W-1:0]] ^ base;
      end else if (!second_half) begin
        line_d = ~line_q;
      end else begin
        line_d = line_q ^ sub_bits[slot];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      base_q <= 1'b0;
    end else begin
      line_q <= line_d;
      base_q <= base_d;
    end
  end

  assign line = line_q;

endmodule

// File: rtl/bmc_tx_serializer.sv
module bmc_tx_serializer
  import bmc_tx_pkg::*;
#(
  parameter int BLK_WORDS = 6,
  parameter int WORD_W    = 32,
  localparam int NFRAMES  = BLK_WORDS * WORD_W,
  localparam int FRM_W    = $clog2(NFRAMES),
  localparam int SEL_W    = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [23:0]       aud_a,
  input  logic [23:0]       aud_b,
  input  logic              smp_avail,
  output logic              smp_take,
  input  logic              val_a,
  input  logic              val_b,
  input  logic              null_ok,
  input  logic              cs_wr,
  input  logic [SEL_W-1:0]  cs_sel,
  input  logic [WORD_W-1:0] cs_wdata,
  output logic              cs_rdy,
  input  logic              ud_wr,
  input  logic [SEL_W-1:0]  ud_sel,
  input  logic [WORD_W-1:0] ud_wdata,
  output logic              ud_rdy,
  output logic              block_end,
  output logic              sdo
);

  logic [HC_W-1:0]  hc;
  logic [FRM_W-1:0] frm;
  logic             frame_start;
  logic             copy;
  logic             cs_bit;
  logic             ud_bit;
  logic [SLOTS-1:0] sub_bits;

  bmc_tx_timer #(.NFRAMES(NFRAMES)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .hc          (hc),
    .frm         (frm),
    .frame_start (frame_start),
    .block_end   (block_end)
  );

  assign copy = block_end || !tx_en;

  bmc_tx_blockbuf #(.WORDS(BLK_WORDS), .WORD_W(WORD_W)) u_csbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cs_wr),
    .sel     (cs_sel),
    .wdata   (cs_wdata),
    .copy    (copy),
    .bit_idx (frm),
    .bit_o   (cs_bit),
    .rdy     (cs_rdy)
  );

  bmc_tx_blockbuf #(.WORDS(BLK_WORDS), .WORD_W(WORD_W)) u_udbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (ud_wr),
    .sel     (ud_sel),
    .wdata   (ud_wdata),
    .copy    (copy),
    .bit_idx (frm),
    .bit_o   (ud_bit),
    .rdy     (ud_rdy)
  );

  bmc_tx_framer u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .smp_avail   (smp_avail),
    .aud_a       (aud_a),
    .aud_b       (aud_b),
    .val_a       (val_a),
    .val_b       (val_b),
    .null_ok     (null_ok),
    .cs_bit      (cs_bit),
    .ud_bit      (ud_bit),
    .sub_sel     (hc[HC_W-1]),
    .sub_bits    (sub_bits),
    .smp_take    (smp_take)
  );

  bmc_tx_encoder u_encoder (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .hc          (hc),
    .first_frame (frm == '0),
    .sub_bits    (sub_bits),
    .line        (sdo)
  );

endmodule

// File: rtl/bmc_tx_checker.sv
module bmc_tx_checker
  import bmc_tx_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            tx_en,
  input logic [HC_W-1:0] hc,
  input logic            sdo,
  input logic            smp_take,
  input logic            block_end,
  input logic            cs_wr,
  input logic            cs_rdy,
  input logic            ud_wr,
  input logic            ud_rdy
);

  logic data_slot_start;
  assign data_slot_start = tx_en && !hc[0] && (hc[SUB_W-1:0] >= SUB_W'(PRE_HALVES));

  // R1: line held low once transmission is off
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (sdo == 1'b0));

  // R3: each data slot opens with a level change
  a_r3_slot_edge: assert property (@(posedge clk) disable iff (!rst_n)
    data_slot_start |=> (sdo != $past(sdo)));

  // R6: a sample pair is taken at most once per frame
  a_r6_take_single: assert property (@(posedge clk) disable iff (!rst_n)
    smp_take |=> !smp_take);

  // R12: block end is a single-cycle pulse
  a_r12_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    block_end |=> !block_end);

  // R11: a write drops the ready flag
  a_r11_cs_drop: assert property (@(posedge clk) disable iff (!rst_n)
    cs_wr |=> !cs_rdy);

  a_r11_ud_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ud_wr |=> !ud_rdy);

  // R11: ready only rises after a copy point
  a_r11_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_rdy) |-> ($past(block_end) || !$past(tx_en)));

  a_r11_ud_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ud_rdy) |-> ($past(block_end) || !$past(tx_en)));

endmodule

bind bmc_tx_serializer bmc_tx_checker u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_en     (tx_en),
  .hc        (hc),
  .sdo       (sdo),
  .smp_take  (smp_take),
  .block_end (block_end),
  .cs_wr     (cs_wr),
  .cs_rdy    (cs_rdy),
  .ud_wr     (ud_wr),
  .ud_rdy    (ud_rdy)
);

// File: tb/bmc_tx_serializer_bench.sv
`timescale 1ns/1ps
module bmc_tx_serializer_bench;

  localparam int BW   = 2;
  localparam int WW   = 8;
  localparam int NF   = BW * WW;
  localparam int SELW = (BW > 1) ? $clog2(BW) : 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tx_en = 1'b0;
  logic [23:0]     aud_a = '0;
  logic [23:0]     aud_b = '0;
  logic            smp_avail = 1'b0;
  logic            smp_take;
  logic            val_a = 1'b0;
  logic            val_b = 1'b0;
  logic            null_ok = 1'b0;
  logic            cs_wr = 1'b0;
  logic [SELW-1:0] cs_sel = '0;
  logic [WW-1:0]   cs_wdata = '0;
  logic            cs_rdy;
  logic            ud_wr = 1'b0;
  logic [SELW-1:0] ud_sel = '0;
  logic [WW-1:0]   ud_wdata = '0;
  logic            ud_rdy;
  logic            block_end;
  logic            sdo;

  always #2.5 clk = ~clk;

  bmc_tx_serializer #(.BLK_WORDS(BW), .WORD_W(WW)) u_bmc_tx_serializer (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .aud_a(aud_a), .aud_b(aud_b),
    .smp_avail(smp_avail), .smp_take(smp_take), .val_a(val_a), .val_b(val_b),
    .null_ok(null_ok), .cs_wr(cs_wr), .cs_sel(cs_sel), .cs_wdata(cs_wdata),
    .cs_rdy(cs_rdy), .ud_wr(ud_wr), .ud_sel(ud_sel), .ud_wdata(ud_wdata),
    .ud_rdy(ud_rdy), .block_end(block_end), .sdo(sdo)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit cmp_on = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit    lvl_q[$];
  bit    ss_q[$];
  string tag_q[$];
  bit    m_sdo = 0;
  bit    m_lvl = 0;
  bit    m_ss  = 0;
  string m_tag = "R1";
  int    m_frame = 0;
  int    m_next  = 0;
  bit    cs_st[NF], cs_sh[NF], ud_st[NF], ud_sh[NF];
  bit    m_cs_rdy = 1, m_ud_rdy = 1;

  int pre_b[8] = '{1,1,1,0,1,0,0,0};
  int pre_m[8] = '{1,1,1,0,0,0,1,0};
  int pre_y[8] = '{1,1,1,0,0,1,0,0};

  task automatic build_frame();
    bit avail;
    m_frame = m_next;
    m_next  = (m_next + 1) % NF;
    avail   = smp_avail;
    for (int ch = 0; ch < 2; ch++) begin
      bit bits[32];
      int par;
      bit [23:0] a;
      bit v;
      a = avail ? (ch == 0 ? aud_a : aud_b) : 24'd0;
      v = avail ? (ch == 0 ? val_a : val_b) : !null_ok;
      for (int s = 0; s < 32; s++) bits[s] = 0;
      for (int i = 0; i < 24; i++) bits[4+i] = a[i];
      bits[28] = v;
      bits[29] = ud_sh[m_frame];
      bits[30] = cs_sh[m_frame];
      par = 0;
      for (int s = 4; s < 31; s++) par += bits[s];
      bits[31] = par % 2;
      for (int i = 0; i < 8; i++) begin
        int p;
        p = (ch == 1) ? pre_y[i] : ((m_frame == 0) ? pre_b[i] : pre_m[i]);
        lvl_q.push_back(bit'(p) ^ m_lvl);
        ss_q.push_back(0);
        tag_q.push_back("R4");
      end
      m_lvl = lvl_q[$];
      for (int s = 4; s < 32; s++) begin
        string t;
        if (s < 28) t = avail ? "R2" : "R7";
        else if (s == 28) t = avail ? "R8" : "R7";
        else if (s == 29) t = "R9";
        else if (s == 30) t = "R10";
        else t = "R5";
        m_lvl = !m_lvl;
        lvl_q.push_back(m_lvl); ss_q.push_back(1); tag_q.push_back(t);
        if (bits[s]) m_lvl = !m_lvl;
        lvl_q.push_back(m_lvl); ss_q.push_back(0); tag_q.push_back(t);
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      lvl_q.delete(); ss_q.delete(); tag_q.delete();
      m_sdo = 0; m_lvl = 0; m_ss = 0; m_tag = "R1"; m_frame = 0; m_next = 0;
      for (int k = 0; k < NF; k++) begin
        cs_st[k] = 0; cs_sh[k] = 0; ud_st[k] = 0; ud_sh[k] = 0;
      end
      m_cs_rdy = 1; m_ud_rdy = 1;
    end else begin
      bit be, cp;
      be = tx_en && lvl_q.size() == 1 && m_frame == NF - 1;
      cp = !tx_en || be;
      if (tx_en) begin
        if (lvl_q.size() == 0) build_frame();
        m_sdo = lvl_q.pop_front();
        m_ss  = ss_q.pop_front();
        m_tag = tag_q.pop_front();
      end else begin
        lvl_q.delete(); ss_q.delete(); tag_q.delete();
        m_sdo = 0; m_lvl = 0; m_ss = 0; m_tag = "R1"; m_next = 0; m_frame = 0;
      end
      if (cp) begin
        for (int k = 0; k < NF; k++) begin cs_sh[k] = cs_st[k]; ud_sh[k] = ud_st[k]; end
      end
      if (cs_wr && int'(cs_sel) < BW)
        for (int j = 0; j < WW; j++) cs_st[int'(cs_sel)*WW+j] = cs_wdata[j];
      if (ud_wr && int'(ud_sel) < BW)
        for (int j = 0; j < WW; j++) ud_st[int'(ud_sel)*WW+j] = ud_wdata[j];
      m_cs_rdy = cs_wr ? 0 : (cp ? 1 : m_cs_rdy);
      m_ud_rdy = ud_wr ? 0 : (cp ? 1 : m_ud_rdy);
    end
  end

  bit prev_sdo = 0;
  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      bit et, eb;
      et = tx_en && lvl_q.size() == 0 && smp_avail;
      eb = tx_en && lvl_q.size() == 1 && m_frame == NF - 1;
      chk(sdo === m_sdo, m_tag, "sdo", sdo, m_sdo);
      if (tx_en && m_ss) chk(sdo !== prev_sdo, "R3", "slot start edge", sdo, !prev_sdo);
      chk(smp_take === et, "R6", "smp_take", smp_take, et);
      chk(block_end === eb, "R12", "block_end", block_end, eb);
      chk(cs_rdy === m_cs_rdy, "R11", "cs_rdy", cs_rdy, m_cs_rdy);
      chk(ud_rdy === m_ud_rdy, "R11", "ud_rdy", ud_rdy, m_ud_rdy);
    end
    prev_sdo = sdo;
  end

  // ---------------- stimulus ----------------
  int unsigned seed = 32'h1234_5678;
  initial begin
    forever begin
      @(posedge clk); #1;
      seed  = seed * 32'd1103515245 + 32'd12345;
      aud_a = seed[31:8];
      seed  = seed * 32'd1103515245 + 32'd12345;
      aud_b = seed[31:8];
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic cs_write(input int sel, input int data);
    cs_wr = 1; cs_sel = SELW'(sel); cs_wdata = WW'(data);
    step(1);
    cs_wr = 0;
  endtask

  task automatic ud_write(input int sel, input int data);
    ud_wr = 1; ud_sel = SELW'(sel); ud_wdata = WW'(data);
    step(1);
    ud_wr = 0;
  endtask

  initial begin
    step(4);
    rst_n = 1;
    @(negedge clk);
    chk(sdo == 0, "R1", "sdo after reset", sdo, 0);
    chk(cs_rdy == 1, "R1", "cs_rdy after reset", cs_rdy, 1);
    chk(ud_rdy == 1, "R1", "ud_rdy after reset", ud_rdy, 1);
    chk(smp_take == 0, "R1", "smp_take idle", smp_take, 0);
    chk(block_end == 0, "R1", "block_end idle", block_end, 0);
    cmp_on = 1;
    step(2);

    // load blocks while idle
    cs_write(0, 8'hA5);
    @(negedge clk);
    chk(cs_rdy == 0, "R11", "cs_rdy after write", cs_rdy, 0);
    step(1);
    @(negedge clk);
    chk(cs_rdy == 1, "R11", "cs_rdy after idle copy", cs_rdy, 1);
    cs_write(1, 8'h3C);
    ud_write(0, 8'h0F);
    ud_write(1, 8'hF1);
    step(3);

    // stream with samples
    smp_avail = 1; val_a = 0; val_b = 1; null_ok = 0;
    tx_en = 1;
    step(NF * 128 + 300);

    // mid-block update, must wait for block end
    cs_write(0, 8'h5A);
    ud_write(1, 8'h81);
    step(20);
    @(negedge clk);
    chk(cs_rdy == 0, "R10", "cs_rdy held until block end", cs_rdy, 0);
    step(NF * 128 + 100);

    // validity changes
    val_a = 1; val_b = 0;
    step(700);

    // underrun, both markings
    smp_avail = 0; null_ok = 0;
    step(600);
    null_ok = 1;
    step(600);
    smp_avail = 1;
    step(NF * 128);

    // disable mid-frame, restart
    step(37);
    tx_en = 0;
    step(10);
    tx_en = 1;
    @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(sdo == bit'(pre_b[i]), "R13", "restart preamble", sdo, pre_b[i]);
    end
    step(NF * 128 + 200);
    tx_en = 0;
    step(10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule